// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the protocol engine of a two-wire serial EEPROM holding 16K bytes. It watches the already filtered clock and data lines together with separate start and stop pulses. When the first byte names its device, it acknowledges. It then either takes a two-byte word address and data bytes, or streams stored bytes back to the master. Written bytes go out one at a time, each with its target address, to a page buffer. A commit pulse on stop tells the write engine to begin its internal cycle. Reads go through a one-cycle synchronous read port into the array.

A single address pointer survives from one transaction to the next. A read that sends no word address therefore continues from the byte after the last one touched. A random read is made by sending a write-type header that only loads the pointer, then a repeated start with the read bit set. While the write engine reports busy, the block ignores the bus entirely. A master finds out that a write has finished by polling with the device address until an acknowledge comes back.

The controller is a state machine with eleven states:
- `ST_IDLE`: standby.
- `ST_DEV`: device byte being received.
- `ST_DEV_ACK`: device acknowledge.
- `ST_AHI` and `ST_AHI_ACK`: high address byte and its acknowledge.
- `ST_ALO` and `ST_ALO_ACK`: low address byte and its acknowledge.
- `ST_WDAT` and `ST_WDAT_ACK`: write data byte and its acknowledge.
- `ST_RDAT`: data bits being driven out.
- `ST_RACK`: master acknowledge after a read byte.

Transitions:
- A start pulse moves any state to `ST_DEV`. A stop pulse moves any state to `ST_IDLE`.
- After eight bits in `ST_DEV`, the next SCL fall goes to `ST_DEV_ACK` on a match, or to `ST_IDLE` on a mismatch or while busy.
- `ST_DEV_ACK` leaves on an SCL fall: to `ST_RDAT` for a read, to `ST_AHI` for a write.
- For a write, each receive state goes to its acknowledge state after eight bits. Each acknowledge state then goes to the next receive state: `ST_AHI_ACK` to `ST_ALO`, `ST_ALO_ACK` to `ST_WDAT`, and `ST_WDAT_ACK` back to `ST_WDAT`.
- `ST_RDAT` goes to `ST_RACK` after eight bits.
- `ST_RACK` goes back to `ST_RDAT` when the master acknowledged, or to `ST_IDLE` when it did not.

Top module: `twi_eeprom_slave`

## Requirements
- R1: The first byte after a start is compared MSB first. Bits 7..4 must be 1010, bits 3..1 must equal `strap_i[2:0]`, and bit 0 is the read (1) or write (0) flag. On a match, `sda_pull_o` is 1 for the whole ninth SCL clock.
- R2: On a device byte mismatch the block never asserts `sda_pull_o`, and ignores all later bytes until the next start, including any address bytes, which leave the pointer unchanged.
- R3: A write carries a high address byte, a low address byte, then data bytes, each acknowledged on its ninth clock. Only the low 6 bits of the high byte are kept, forming a 14-bit address. Each data byte is emitted once on `pb_we_o` with `pb_addr_o` and `pb_data_o`, and never in the same cycle as `rd_en_o`.
- R4: During a write, the address of successive data bytes advances only in its low 6 bits, wrapping within the 64-byte page; bits 13..6 never change.
- R5: A stop after at least one complete data byte gives exactly one `commit_o` pulse, in the cycle after the stop pulse. A stop after an address-only write gives none, and a start in the middle of a write discards it with no commit.
- R6: Read data leaves MSB first, with `sda_pull_o` = inverse of the bit. A master acknowledge (0) continues with the next address. A missing acknowledge ends the read, and nothing is driven until the next start.
- R7: The read address advances from 16383 to 0.
- R8: After every access, the pointer holds the last byte address accessed plus one. After writes this uses the page wrap of R4. A read without a word address starts at the pointer.
- R9: A write-type header with a word address, followed by a repeated start with the read flag, returns data from that word address.
- R10: While `busy_i` is 1, the device byte is not acknowledged and `sda_pull_o` stays 0.
- R11: `sda_pull_o` changes only in the cycle after a detected SCL falling edge, or after a start or stop pulse. It never changes while SCL is high otherwise.
- R12: After reset, `sda_pull_o` is 0 and the pointer is 0, so a first current read returns address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Filtered serial clock level |
| sda_i | input | 1 | Filtered serial data level |
| start_i | input | 1 | One-cycle start condition pulse |
| stop_i | input | 1 | One-cycle stop condition pulse |
| strap_i | input | 3 | Board strap bits of the device address |
| busy_i | input | 1 | Internal write cycle in progress |
| rd_data_i | input | 8 | Array read data, valid the cycle after `rd_en_o` |
| sda_pull_o | output | 1 | Pull SDA low when 1 |
| rd_en_o | output | 1 | Array read strobe |
| rd_addr_o | output | 14 | Array read address |
| pb_we_o | output | 1 | Page buffer byte strobe |
| pb_addr_o | output | 14 | Page buffer byte address |
| pb_data_o | output | 8 | Page buffer byte data |
| commit_o | output | 1 | Start internal write cycle |

## Verification
The hardest situation to reach is a device byte arriving while the internal write cycle is still running. The bench models the write engine as a busy counter that is loaded when `commit_o` appears. It polls with the device address straight after a stop, then polls again once busy drops.

Address wrap at the array top and at a page edge is reached by writing near 0x3FFE and then reading sequentially across 16383. The pointer's persistence is exposed through current reads placed after a mismatched header and after an aborted write.

// File: rtl/twi_pkg.sv
package twi_pkg;
    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam int         STRAP_W  = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK
    } state_t;
endpackage

// File: rtl/twi_edge.sv
module twi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    logic scl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scl_q <= 1'b1;
        else        scl_q <= scl_i;
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/twi_ptr.sv
module twi_ptr #(
    parameter int AW = 14,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          inc_all_i,
    input  logic          inc_page_i,
    output logic [AW-1:0] ptr_o
);
    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ptr_q <= '0;
        else if (load_i)     ptr_q <= load_val_i;
        else if (inc_all_i)  ptr_q <= ptr_q + 1'b1;
        else if (inc_page_i) ptr_q <= {ptr_q[AW-1:PW], ptr_q[PW-1:0] + 1'b1};
    end

    assign ptr_o = ptr_q;

    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_all_i && !load_i && ptr_q == {AW{1'b1}}) |=> (ptr_q == '0));

    // R4
    page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_page_i && !load_i && !inc_all_i) |=> (ptr_q[AW-1:PW] == $past(ptr_q[AW-1:PW])));
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
    import twi_pkg::*;
#(
    parameter int AW = 14,
    parameter int PW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    input  logic [7:0]         rd_data_i,
    output logic               sda_pull_o,
    output logic               rd_en_o,
    output logic [AW-1:0]      rd_addr_o,
    output logic               pb_we_o,
    output logic [AW-1:0]      pb_addr_o,
    output logic [7:0]         pb_data_o,
    output logic               commit_o
);
    localparam int HW = AW - 8;

    state_t        state_q, state_d;
    logic [3:0]    cnt_q, cnt_d;
    logic [7:0]    sh_q, sh_d;
    logic [7:0]    tx_q;
    logic [HW-1:0] hi_q, hi_d;
    logic          rw_q, rw_d;
    logic          mack_q, mack_d;
    logic          seen_q, seen_d;
    logic          rd_dly_q;
    logic          pull_d, rd_go, pb_go, commit_go, tx_shift;
    logic          p_load, p_inc_all, p_inc_page;
    logic          scl_rise, scl_fall;
    logic [AW-1:0] ptr;
    logic          byte_full, rx_state, dev_hit;

    twi_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall)
    );

    twi_ptr #(.AW(AW), .PW(PW)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (p_load),
        .load_val_i ({hi_q, sh_q}),
        .inc_all_i  (p_inc_all),
        .inc_page_i (p_inc_page),
        .ptr_o      (ptr)
    );

    assign byte_full = (cnt_q == 4'd8);
    assign rx_state  = (state_q == ST_DEV) || (state_q == ST_AHI) ||
                       (state_q == ST_ALO) || (state_q == ST_WDAT);
    assign dev_hit   = (sh_q[7:4] == DEV_CODE) && (sh_q[3:1] == strap_i) && !busy_i;

    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        sh_d       = sh_q;
        hi_d       = hi_q;
        rw_d       = rw_q;
        mack_d     = mack_q;
        seen_d     = seen_q;
        pull_d     = sda_pull_o;
        rd_go      = 1'b0;
        pb_go      = 1'b0;
        commit_go  = 1'b0;
        tx_shift   = 1'b0;
        p_load     = 1'b0;
        p_inc_all  = 1'b0;
        p_inc_page = 1'b0;
        if (start_i) begin
            state_d = ST_DEV;
            cnt_d   = '0;
            pull_d  = 1'b0;
            seen_d  = 1'b0;
        end else if (stop_i) begin
            state_d   = ST_IDLE;
            pull_d    = 1'b0;
            commit_go = seen_q;
            seen_d    = 1'b0;
        end else begin
            if (rx_state && scl_rise && !byte_full) begin
                sh_d  = {sh_q[6:0], sda_i};
                cnt_d = cnt_q + 4'd1;
            end
            unique case (state_q)
                ST_IDLE: ;
                ST_DEV: begin
                    if (scl_fall && byte_full) begin
                        if (dev_hit) begin
                            pull_d  = 1'b1;
                            rw_d    = sh_q[0];
                            state_d = ST_DEV_ACK;
                            if (sh_q[0]) begin
                                rd_go     = 1'b1;
                                p_inc_all = 1'b1;
                            end
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        cnt_d = '0;
                        if (rw_q) begin
                            state_d  = ST_RDAT;
                            pull_d   = ~tx_q[7];
                            tx_shift = 1'b1;
                        end else begin
                            state_d = ST_AHI;
                            pull_d  = 1'b0;
                        end
                    end
                end
                ST_AHI: begin
                    if (scl_fall && byte_full) begin
                        pull_d  = 1'b1;
                        hi_d    = sh_q[HW-1:0];
                        state_d = ST_AHI_ACK;
                    end
                end
                ST_AHI_ACK: begin
                    if (scl_fall) begin
                        pull_d  = 1'b0;
                        cnt_d   = '0;
                        state_d = ST_ALO;
                    end
                end
                ST_ALO: begin
                    if (scl_fall && byte_full) begin
                        pull_d  = 1'b1;
                        p_load  = 1'b1;
                        state_d = ST_ALO_ACK;
                    end
                end
                ST_ALO_ACK: begin
                    if (scl_fall) begin
                        pull_d  = 1'b0;
                        cnt_d   = '0;
                        state_d = ST_WDAT;
                    end
                end
                ST_WDAT: begin
                    if (scl_fall && byte_full) begin
                        pull_d     = 1'b1;
                        pb_go      = 1'b1;
                        p_inc_page = 1'b1;
                        seen_d     = 1'b1;
                        state_d    = ST_WDAT_ACK;
                    end
                end
                ST_WDAT_ACK: begin
                    if (scl_fall) begin
                        pull_d  = 1'b0;
                        cnt_d   = '0;
                        state_d = ST_WDAT;
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        cnt_d = cnt_q + 4'd1;
                    end else if (scl_fall) begin
                        if (byte_full) begin
                            pull_d  = 1'b0;
                            state_d = ST_RACK;
                        end else begin
                            pull_d   = ~tx_q[7];
                            tx_shift = 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack_d = ~sda_i;
                        if (!sda_i) begin
                            rd_go     = 1'b1;
                            p_inc_all = 1'b1;
                        end
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            state_d  = ST_RDAT;
                            cnt_d    = '0;
                            pull_d   = ~tx_q[7];
                            tx_shift = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            sh_q     <= '0;
            hi_q     <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            seen_q   <= 1'b0;
            rd_dly_q <= 1'b0;
            tx_q     <= '0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            sh_q     <= sh_d;
            hi_q     <= hi_d;
            rw_q     <= rw_d;
            mack_q   <= mack_d;
            seen_q   <= seen_d;
            rd_dly_q <= rd_en_o;
            if (rd_dly_q)      tx_q <= rd_data_i;
            else if (tx_shift) tx_q <= {tx_q[6:0], 1'b0};
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull_o <= 1'b0;
            rd_en_o    <= 1'b0;
            rd_addr_o  <= '0;
            pb_we_o    <= 1'b0;
            pb_addr_o  <= '0;
            pb_data_o  <= '0;
            commit_o   <= 1'b0;
        end else begin
            sda_pull_o <= pull_d;
            rd_en_o    <= rd_go;
            pb_we_o    <= pb_go;
            commit_o   <= commit_go;
            if (rd_go) rd_addr_o <= ptr;
            if (pb_go) begin
                pb_addr_o <= ptr;
                pb_data_o <= sh_q;
            end
        end
    end

    // R11
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> ($past(scl_fall) || $past(start_i) || $past(stop_i)));

    // R10
    busy_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && $past(busy_i) && !$past(sda_pull_o)) |-> !sda_pull_o);

    // R5
    commit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(stop_i));

    // R3
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pb_we_o && rd_en_o));
endmodule

// File: tb/twi_eeprom_slave_bench.sv
module twi_eeprom_slave_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        start_p = 1'b0;
    logic        stop_p = 1'b0;
    logic [2:0]  strap = 3'b101;
    logic [7:0]  rd_data = '0;
    logic        sda_pull, rd_en, pb_we, commit;
    logic [13:0] rd_addr, pb_addr;
    logic [7:0]  pb_data;
    logic        sda_bus, busy;

    int          checks = 0;
    int          fails = 0;
    int          busy_cnt = 0;
    int          commits = 0;
    int          pulls = 0;
    bit          done = 1'b0;
    logic        pull_prev = 1'b0;
    logic        scl_prev = 1'b1;
    logic        ev_q = 1'b0;
    logic [7:0]  mem [int];
    int          pbq_a [$];
    logic [7:0]  pbq_d [$];
    int          log_a [$];
    logic [7:0]  log_d [$];

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;
    assign busy    = (busy_cnt != 0);

    twi_eeprom_slave u_twi_eeprom_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .start_i    (start_p),
        .stop_i     (stop_p),
        .strap_i    (strap),
        .busy_i     (busy),
        .rd_data_i  (rd_data),
        .sda_pull_o (sda_pull),
        .rd_en_o    (rd_en),
        .rd_addr_o  (rd_addr),
        .pb_we_o    (pb_we),
        .pb_addr_o  (pb_addr),
        .pb_data_o  (pb_data),
        .commit_o   (commit)
    );

    function automatic logic [7:0] init_val(int a);
        return 8'((a * 37 + 11) ^ (a >> 5));
    endfunction

    function automatic logic [7:0] memval(int a);
        if (mem.exists(a)) return mem[a];
        return init_val(a);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // array and write engine model
    always @(posedge clk) begin
        if (rd_en) rd_data <= memval(int'(rd_addr));
        ev_q <= start_p | stop_p;
        if (sda_pull) pulls <= pulls + 1;
        if (start_p) begin
            pbq_a.delete();
            pbq_d.delete();
        end
        if (pb_we) begin
            pbq_a.push_back(int'(pb_addr));
            pbq_d.push_back(pb_data);
            log_a.push_back(int'(pb_addr));
            log_d.push_back(pb_data);
        end
        if (commit) begin
            foreach (pbq_a[i]) mem[pbq_a[i]] = pbq_d[i];
            pbq_a.delete();
            pbq_d.delete();
            commits <= commits + 1;
            busy_cnt <= 300;
        end else if (busy_cnt != 0) begin
            busy_cnt <= busy_cnt - 1;
        end
    end

    // R11: SDA drive never moves while SCL stays high, compared every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(!(sda_pull != pull_prev && scl && scl_prev && !ev_q), "R11",
                  int'(sda_pull), int'(pull_prev));
        end
        pull_prev <= sda_pull;
        scl_prev  <= scl;
    end

    task automatic clk_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic s);
        scl = 1'b0;
        clk_n(4);
        sda_m = b;
        clk_n(4);
        scl = 1'b1;
        clk_n(4);
        s = sda_bus;
        clk_n(4);
    endtask

    task automatic do_start();
        scl = 1'b0;
        clk_n(4);
        sda_m = 1'b1;
        clk_n(4);
        scl = 1'b1;
        clk_n(4);
        sda_m = 1'b0;
        start_p = 1'b1;
        clk_n(1);
        start_p = 1'b0;
        clk_n(3);
    endtask

    task automatic do_stop();
        scl = 1'b0;
        clk_n(4);
        sda_m = 1'b0;
        clk_n(4);
        scl = 1'b1;
        clk_n(4);
        sda_m = 1'b1;
        stop_p = 1'b1;
        clk_n(1);
        stop_p = 1'b0;
        clk_n(3);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bit_io(1'b1, s);
            d = {d[6:0], s};
        end
        bit_io(~mack, s);
    endtask

    function automatic logic [7:0] dev(logic [2:0] st, logic rd);
        return {4'b1010, st, rd};
    endfunction

    initial begin
        logic       ack;
        logic [7:0] d;
        int         c0;

        clk_n(5);
        rst_n = 1'b1;
        clk_n(2);
        check(sda_pull == 1'b0, "R12 reset release", int'(sda_pull), 0);

        // current read straight after reset
        do_start();
        send_byte(dev(strap, 1'b1), ack);
        check(ack == 1'b1, "R1 read header ack", int'(ack), 1);
        recv_byte(1'b0, d);
        check(d == memval(0), "R12 first read at 0", int'(d), int'(memval(0)));
        do_stop();
        check(sda_pull == 1'b0, "R6 released after nack", int'(sda_pull), 0);

        // page write at 0x3FFE, high byte bits 7..6 set
        log_a.delete();
        log_d.delete();
        c0 = commits;
        do_start();
        send_byte(dev(strap, 1'b0), ack);
        check(ack == 1'b1, "R1 write header ack", int'(ack), 1);
        send_byte(8'hFF, ack);
        check(ack == 1'b1, "R3 high address ack", int'(ack), 1);
        send_byte(8'hFE, ack);
        check(ack == 1'b1, "R3 low address ack", int'(ack), 1);
        send_byte(8'h11, ack);
        check(ack == 1'b1, "R3 data ack", int'(ack), 1);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack);
        check(ack == 1'b1, "R3 third data ack", int'(ack), 1);
        check(log_a.size() == 3, "R3 byte count", log_a.size(), 3);
        if (log_a.size() == 3) begin
            check(log_a[0] == 'h3FFE, "R3 address bits 15..14 dropped", log_a[0], 'h3FFE);
            check(log_d[1] == 8'h22, "R3 data stream", int'(log_d[1]), 'h22);
            check(log_a[2] == 'h3FC0, "R4 page wrap", log_a[2], 'h3FC0);
        end
        do_stop();
        clk_n(2);
        check(commits == c0 + 1, "R5 commit on stop", commits, c0 + 1);

        // polling while busy
        do_start();
        send_byte(dev(strap, 1'b0), ack);
        check(ack == 1'b0, "R10 no ack while busy", int'(ack), 0);
        do_stop();
        wait (busy_cnt == 0);
        clk_n(2);
        c0 = commits;
        do_start();
        send_byte(dev(strap, 1'b0), ack);
        check(ack == 1'b1, "R10 ack after busy", int'(ack), 1);
        do_stop();
        clk_n(2);
        check(commits == c0, "R5 header-only write no commit", commits, c0);

        // current read continues after page write
        do_start();
        send_byte(dev(strap, 1'b1), ack);
        recv_byte(1'b1, d);
        check(d == memval('h3FC1), "R8 pointer after write", int'(d), int'(memval('h3FC1)));
        recv_byte(1'b0, d);
        check(d == memval('h3FC2), "R6 sequential next", int'(d), int'(memval('h3FC2)));
        do_stop();

        // random read through the array top
        do_start();
        send_byte(dev(strap, 1'b0), ack);
        send_byte(8'h3F, ack);
        send_byte(8'hFE, ack);
        do_start();
        send_byte(dev(strap, 1'b1), ack);
        check(ack == 1'b1, "R9 repeated start ack", int'(ack), 1);
        recv_byte(1'b1, d);
        check(d == 8'h11, "R9 random read data", int'(d), 'h11);
        recv_byte(1'b1, d);
        check(d == 8'h22, "R6 sequential second", int'(d), 'h22);
        recv_byte(1'b0, d);
        check(d == memval(0), "R7 wrap to zero", int'(d), int'(memval(0)));
        do_stop();

        // wrong strap: nothing driven, pointer untouched
        pulls = 0;
        do_start();
        send_byte(dev(3'b011, 1'b0), ack);
        check(ack == 1'b0, "R2 mismatch no ack", int'(ack), 0);
        send_byte(8'h00, ack);
        send_byte(8'h40, ack);
        check(pulls == 0, "R2 never drives", pulls, 0);
        do_stop();
        do_start();
        send_byte(dev(strap, 1'b1), ack);
        recv_byte(1'b0, d);
        check(d == memval(1), "R2 pointer unchanged", int'(d), int'(memval(1)));
        do_stop();

        // write aborted by a repeated start
        c0 = commits;
        do_start();
        send_byte(dev(strap, 1'b0), ack);
        send_byte(8'h00, ack);
        send_byte(8'h05, ack);
        send_byte(8'h55, ack);
        do_start();
        send_byte(dev(strap, 1'b1), ack);
        recv_byte(1'b0, d);
        check(d == memval(6), "R8 pointer after aborted write", int'(d), int'(memval(6)));
        do_stop();
        clk_n(2);
        check(commits == c0, "R5 start aborts write", commits, c0);
        check(memval(5) == init_val(5), "R5 aborted data not stored", int'(memval(5)), int'(init_val(5)));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule